// File: doc/BRIEF.md
# Pipelined Odd-Even Transposition Sorter

This block orders a vector of `LANES` unsigned samples, each `WIDTH` bits wide, that arrive together on one clock. It is built from `LANES` registered stages of compare-exchange cells. Each stage compares neighbouring lanes. Stages alternate between pairs that start on even lanes (stage 0, 2, …) and pairs that start on odd lanes (stage 1, 3, …). A lane that has no partner in a stage goes through a one-clock delay register, so every path through the network has the same depth.

A new vector may be offered on every clock. The sorted result appears exactly `LANES` clocks later, whatever the data values are. All lanes are presented in parallel: the largest value is on the top lane and the smallest is on the bottom lane. A valid flag travels through the pipeline beside the data. The user selects any rank, for example the median, from the sorted lanes. Intended sizes are 5, 9, 25 and 49 lanes.

Lane `i` occupies bits `[i*WIDTH +: WIDTH]` of both `in_data` and `out_data`. Lane 0 is the top lane.

Top module: `sortnet_pipe`

## Requirements
- R1: `out_valid` is high in the cycle that follows the `LANES`-th rising edge after `in_valid` was sampled high. The pattern of `out_valid`, including gaps, is the `in_valid` pattern delayed by exactly `LANES` clocks.
- R2: When `out_valid` is high, the output holds the same values as the matching input vector. They are ordered non-increasing from lane 0 (largest) to lane `LANES-1` (smallest).
- R3: Vectors presented on consecutive clocks each produce their own sorted result, on consecutive clocks and in the same order (one vector per clock).
- R4: Repeated values, all-equal vectors and the extreme codes 0 and 2^WIDTH-1 are sorted correctly.
- R5: An active-low asynchronous reset forces `out_valid` low at once. `out_valid` then stays low until a vector accepted after the release has crossed all `LANES` stages. Vectors that were in flight at reset never appear as valid.
- R6: While `out_valid` is low, `out_data` keeps the value it last presented. Data offered with `in_valid` low has no effect on the outputs.
- R7: A vector in fully reversed order (smallest on lane 0) comes out fully sorted after the `LANES` stages. This is the worst case for an odd-even network.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears the valid pipeline |
| in_valid | input | 1 | Input vector qualifier |
| in_data | input | LANES*WIDTH | Unsorted samples, lane i at bits [i*WIDTH +: WIDTH] |
| out_valid | output | 1 | Sorted vector qualifier, `in_valid` delayed by LANES clocks |
| out_data | output | LANES*WIDTH | Sorted samples, lane 0 largest |

## Verification
The assertions assume that `in_valid` is a known 0 or 1 on every rising edge after reset. They also assume that the release of `rst_n` happens away from a clock edge. In-flight data is qualified only by the stage valid flags. The bench changes `rst_n`, `in_valid` and `in_data` only on falling edges and drives `in_valid` on every cycle. It offers deliberately non-zero data while `in_valid` is low, so that the hold behaviour is exercised rather than assumed.

// File: rtl/sortnet_pkg.sv
package sortnet_pkg;

  // Stage s compares pairs that start on lanes with parity s % 2.
  function automatic int stage_parity(input int stage);
    return stage % 2;
  endfunction

  // Lane i is the upper member of a compare pair in this stage.
  function automatic bit is_pair_head(input int lane, input int par, input int lanes);
    return ((lane % 2) == par) && ((lane + 1) < lanes);
  endfunction

  // Lane i is the lower member of a compare pair in this stage.
  function automatic bit is_pair_tail(input int lane, input int par, input int lanes);
    return (lane >= 1) && (((lane - 1) % 2) == par) && (lane < lanes);
  endfunction

endpackage

// File: rtl/sortnet_cmpx.sv
module sortnet_cmpx #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo
);

  logic             swap;
  logic [WIDTH-1:0] hi_d, lo_d;
  logic [WIDTH-1:0] hi_q, lo_q;

  // Exchange only when the lower input is strictly larger; ties keep their order.
  always_comb begin
    swap = (b > a);
    hi_d = swap ? b : a;
    lo_d = swap ? a : b;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;

  // R2
  cmpx_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (hi_q >= lo_q));

  // R6
  cmpx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(hi_q) && $stable(lo_q)));

endmodule

// File: rtl/sortnet_dly.sv
module sortnet_dly #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_d, q_q;

  always_comb begin
    q_d = d;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      q_q <= q_d;
    end
  end

  assign q = q_q;

  // R6
  dly_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q_q));

endmodule

// File: rtl/sortnet_stage.sv
module sortnet_stage
  import sortnet_pkg::*;
#(
  parameter int LANES = 5,
  parameter int WIDTH = 8,
  parameter int STAGE = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [LANES*WIDTH-1:0] d_in,
  output logic [LANES*WIDTH-1:0] d_out
);

  localparam int PAR = stage_parity(STAGE);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (is_pair_head(i, PAR, LANES)) begin : g_cmp
      sortnet_cmpx #(.WIDTH(WIDTH)) u_cmpx (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .a    (d_in [i*WIDTH +: WIDTH]),
        .b    (d_in [(i+1)*WIDTH +: WIDTH]),
        .hi   (d_out[i*WIDTH +: WIDTH]),
        .lo   (d_out[(i+1)*WIDTH +: WIDTH])
      );
    end else if (!is_pair_tail(i, PAR, LANES)) begin : g_pass
      sortnet_dly #(.WIDTH(WIDTH)) u_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .d    (d_in [i*WIDTH +: WIDTH]),
        .q    (d_out[i*WIDTH +: WIDTH])
      );
    end
  end

endmodule

// File: rtl/sortnet_pipe.sv
module sortnet_pipe #(
  parameter int LANES = 5,
  parameter int WIDTH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [LANES*WIDTH-1:0] in_data,
  output logic                   out_valid,
  output logic [LANES*WIDTH-1:0] out_data
);

  localparam int DATA_W = LANES * WIDTH;
  localparam int CNT_W  = $clog2(LANES + 1);

  // Valid pipeline: bit s qualifies the output of stage s.
  logic [LANES-1:0] vld_d, vld_q;
  logic [LANES-1:0] stage_en;
  logic [DATA_W-1:0] chain [0:LANES];

  always_comb begin
    vld_d    = {vld_q[LANES-2:0], in_valid};
    stage_en = {vld_q[LANES-2:0], in_valid};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  assign chain[0] = in_data;

  for (genvar s = 0; s < LANES; s++) begin : g_stage
    sortnet_stage #(.LANES(LANES), .WIDTH(WIDTH), .STAGE(s)) u_stage (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (stage_en[s]),
      .d_in (chain[s]),
      .d_out(chain[s+1])
    );
  end

  assign out_valid = vld_q[LANES-1];
  assign out_data  = chain[LANES];

  // Cycles since reset release, saturating at LANES (checker use only).
  logic [CNT_W-1:0] warm_d, warm_q;

  always_comb begin
    warm_d = (warm_q == CNT_W'(LANES)) ? warm_q : warm_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0;
    end else begin
      warm_q <= warm_d;
    end
  end

  // R5
  warmup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q < CNT_W'(LANES)) |-> !out_valid);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == CNT_W'(LANES)) |=> (out_valid == $past(vld_q[LANES-2])));

  for (genvar i = 0; i < LANES - 1; i++) begin : g_ord
    // R2
    sorted_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data[i*WIDTH +: WIDTH] >= out_data[(i+1)*WIDTH +: WIDTH]));
  end

endmodule

// File: tb/sim_sortnet_pipe.sv
module sim_sortnet_pipe;

  localparam int N  = 9;
  localparam int W  = 8;
  localparam int DW = N * W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic          out_valid;
  logic [DW-1:0] out_data;

  always #4 clk = ~clk;

  sortnet_pipe #(.LANES(N), .WIDTH(W)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_data (out_data)
  );

  int checks   = 0;
  int failures = 0;
  bit done     = 0;
  int t        = 0;
  int rst_t    = 0;
  bit known    = 0;
  string scen  = "";
  logic          hv [0:1023];
  logic [DW-1:0] hd [0:1023];
  logic [DW-1:0] last_sorted;

  function automatic logic [DW-1:0] ref_sort(input logic [DW-1:0] d);
    int unsigned a [N];
    int unsigned tmp;
    logic [DW-1:0] r;
    for (int i = 0; i < N; i++) a[i] = d[i*W +: W];
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N - 1 - i; j++)
        if (a[j] < a[j+1]) begin
          tmp = a[j]; a[j] = a[j+1]; a[j+1] = tmp;
        end
    for (int i = 0; i < N; i++) r[i*W +: W] = W'(a[i]);
    return r;
  endfunction

  function automatic logic [DW-1:0] mk(input int seed);
    logic [DW-1:0] r;
    for (int i = 0; i < N; i++) r[i*W +: W] = W'((seed * 37 + i * 91 + 13) % 256);
    return r;
  endfunction

  // One clock: check what the design shows now, then offer the next input.
  task automatic step(input logic v, input logic [DW-1:0] d);
    int idx;
    logic ev;
    logic [DW-1:0] ed;
    @(negedge clk);
    idx = t - N;
    ev  = (idx >= rst_t) ? hv[idx] : 1'b0;
    checks++;
    if (out_valid !== ev) begin
      failures++;
      $display("FAIL R1 [%s] out_valid=%b expected=%b at step %0d", scen, out_valid, ev, t);
    end
    if (ev) begin
      ed = ref_sort(hd[idx]);
      checks++;
      if (out_data !== ed) begin
        failures++;
        $display("FAIL R2 [%s] out_data=%h expected=%h", scen, out_data, ed);
      end
      last_sorted = ed;
      known = 1;
    end else if (known) begin
      checks++;
      if (out_data !== last_sorted) begin
        failures++;
        $display("FAIL R6 [%s] out_data=%h expected held=%h", scen, out_data, last_sorted);
      end
    end
    in_valid = v;
    in_data  = d;
    hv[t] = v;
    hd[t] = d;
    t++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, mk(500 + k));
  endtask

  task automatic test_reset;
    scen = "R5 power-up reset";
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R5 out_valid=%b expected=0 during reset", out_valid);
    end
    @(negedge clk);
    rst_n = 1'b1;
    rst_t = t;
  endtask

  task automatic test_single;
    scen = "R1 single vector latency";
    step(1'b1, mk(1));
    idle(N + 3);
  endtask

  task automatic test_stream;
    scen = "R3 back-to-back stream";
    for (int k = 0; k < 16; k++) step(1'b1, mk(10 + k));
    idle(N + 1);
  endtask

  task automatic test_corners;
    logic [DW-1:0] v;
    scen = "R4 duplicates and extremes";
    step(1'b1, {N{8'h5A}});
    step(1'b1, '0);
    step(1'b1, {N{8'hFF}});
    for (int i = 0; i < N; i++) v[i*W +: W] = (i % 2 == 0) ? 8'hFF : 8'h00;
    step(1'b1, v);
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(i % 3);
    step(1'b1, v);
    scen = "R7 reversed order";
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(i * 20);
    step(1'b1, v);
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(255 - i);
    step(1'b1, v);
    idle(N + 1);
  endtask

  task automatic test_bubbles;
    scen = "R6 gaps and hold";
    for (int k = 0; k < 20; k++) step((k % 3) != 1, mk(40 + k));
    idle(N + 2);
  endtask

  task automatic test_midreset;
    scen = "R5 reset with data in flight";
    for (int k = 0; k < 5; k++) step(1'b1, mk(70 + k));
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R5 out_valid=%b expected=0 right after reset", out_valid);
    end
    @(negedge clk);
    rst_n = 1'b1;
    rst_t = t;
    idle(N + 3);
    scen = "R5 first vector after reset";
    step(1'b1, mk(99));
    idle(N + 1);
  endtask

  initial begin
    test_reset();
    test_single();
    test_stream();
    test_corners();
    test_bubbles();
    test_midreset();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired expected=finish actual=hung");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule